// File: doc/BRIEF.md
# Two-Input Servo Fuzzy Rule Inference

This block is the rule-evaluation core of a small fuzzy controller for a positioning servo. It receives six membership grades, three for the position error (negative, zero, positive) and three for the rate of change of that error (negative, zero, positive). From these it produces three grades for the drive-voltage sets (negative, zero, positive). The fuzzifier that makes the input grades and the defuzzifier that turns the output grades into a crisp drive value sit outside this block.

Each of the nine error/change pairings is one rule. The strength of a rule is the smaller of its two premise grades, and all nine strengths are formed side by side. Rules that point at the same voltage set are merged by taking the largest strength, using a chain of two-input maximum stages. The rule bank is fixed in the wiring. No register lies on any path, so the outputs settle in the same cycle as the inputs.

Top module: `mamdani_servo_infer`

## Requirements
- R1: Each rule's strength is the minimum of its error grade and its change grade. With only one error grade and one change grade non-zero, the output set named by that pair's rule equals the smaller of the two, and the other outputs are 0.
- R2: `act_neg` equals the largest strength among the rules (error negative, change any) and (error zero, change negative).
- R3: `act_pos` equals the largest strength among the rules (error positive, change any) and (error zero, change positive).
- R4: `act_zer` equals the strength of the single rule (error zero, change zero), with no maximum stage on its path.
- R5: When two premise grades are equal, the rule strength equals that shared value, and a maximum over equal strengths returns that value.
- R6: All input grades at 0 give all output grades at 0.
- R7: All input grades at full scale (255 for 8-bit grades) give all output grades at full scale.
- R8: The block holds no state. Outputs take their new values in the same cycle the inputs change, whatever the inputs were before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| err_neg | input | GW | Grade of position error in the negative set |
| err_zer | input | GW | Grade of position error in the zero set |
| err_pos | input | GW | Grade of position error in the positive set |
| chg_neg | input | GW | Grade of error change in the negative set |
| chg_zer | input | GW | Grade of error change in the zero set |
| chg_pos | input | GW | Grade of error change in the positive set |
| act_neg | output | GW | Aggregated grade of the negative voltage set |
| act_zer | output | GW | Grade of the zero voltage set |
| act_pos | output | GW | Aggregated grade of the positive voltage set |

## Verification
The bench targets the two rules with zero error and non-zero change. A design that routes either of them to the wrong voltage set, or drops it from its chain, gives a wrong negative or positive grade as soon as that rule is the strongest one. Single-rule stimuli expose a maximum used where a minimum belongs, because the output then shows the larger premise. Equal premises, all-zero inputs and full-scale inputs catch off-by-one comparisons and truncated widths. Each vector is checked within the cycle it is applied, so any stray register or dependence on the previous vector shows up as a mismatch.

// File: rtl/fz_pkg.sv
package fz_pkg;
    // Membership set index shared by the error, change and voltage axes.
    typedef enum logic [1:0] {
        SET_N = 2'd0,
        SET_Z = 2'd1,
        SET_P = 2'd2
    } fz_set_e;

    localparam int NSET  = 3;
    localparam int NRULE = NSET * NSET;

    // Flat index of the rule for (error set, change set).
    function automatic int rule_idx(input fz_set_e e, input fz_set_e c);
        return int'(e) * NSET + int'(c);
    endfunction
endpackage

// File: rtl/fz_min2.sv
module fz_min2 #(
    parameter int GW = 8
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    output logic [GW-1:0] y
);
    always_comb begin
        y = (a < b) ? a : b;
    end

    // The result must be one of the operands and no larger than either.
    always_comb begin
        p_min_bound_r1: assert ((y <= a) && (y <= b) && ((y == a) || (y == b)))
            else $error("min unit result out of bounds");
        if (a == b) begin
            p_min_equal_r5: assert (y == a)
                else $error("min of equal operands changed value");
        end
    end
endmodule

// File: rtl/fz_max_chain.sv
module fz_max_chain #(
    parameter int GW = 8,
    parameter int N  = 4
) (
    input  logic [N-1:0][GW-1:0] din,
    output logic [GW-1:0]        y
);
    logic [N-1:0][GW-1:0] stage;

    assign stage[0] = din[0];

    // Cascade of two-input maximum stages.
    generate
        for (genvar i = 1; i < N; i++) begin : g_stage
            assign stage[i] = (din[i] > stage[i-1]) ? din[i] : stage[i-1];
        end
    endgenerate

    assign y = stage[N-1];

    always_comb begin
        for (int k = 0; k < N; k++) begin
            p_max_cover_r2: assert (y >= din[k])
                else $error("max chain result below input %0d", k);
        end
    end
endmodule

// File: rtl/mamdani_servo_infer.sv
module mamdani_servo_infer
    import fz_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic [GW-1:0] err_neg,
    input  logic [GW-1:0] err_zer,
    input  logic [GW-1:0] err_pos,
    input  logic [GW-1:0] chg_neg,
    input  logic [GW-1:0] chg_zer,
    input  logic [GW-1:0] chg_pos,
    output logic [GW-1:0] act_neg,
    output logic [GW-1:0] act_zer,
    output logic [GW-1:0] act_pos
);
    localparam int CHAIN = NSET + 1;

    logic [NSET-1:0][GW-1:0]  err_g;
    logic [NSET-1:0][GW-1:0]  chg_g;
    logic [NRULE-1:0][GW-1:0] str;
    logic [CHAIN-1:0][GW-1:0] neg_in;
    logic [CHAIN-1:0][GW-1:0] pos_in;

    assign err_g[SET_N] = err_neg;
    assign err_g[SET_Z] = err_zer;
    assign err_g[SET_P] = err_pos;
    assign chg_g[SET_N] = chg_neg;
    assign chg_g[SET_Z] = chg_zer;
    assign chg_g[SET_P] = chg_pos;

    // Nine parallel rule strengths, one per (error, change) pairing.
    generate
        for (genvar e = 0; e < NSET; e++) begin : g_err
            for (genvar c = 0; c < NSET; c++) begin : g_chg
                fz_min2 #(.GW(GW)) u_min (
                    .a (err_g[e]),
                    .b (chg_g[c]),
                    .y (str[e*NSET + c])
                );
            end
        end
    endgenerate

    // Negative drive: error negative with any change, plus zero error falling.
    assign neg_in[0] = str[rule_idx(SET_N, SET_N)];
    assign neg_in[1] = str[rule_idx(SET_N, SET_Z)];
    assign neg_in[2] = str[rule_idx(SET_N, SET_P)];
    assign neg_in[3] = str[rule_idx(SET_Z, SET_N)];

    // Positive drive: error positive with any change, plus zero error rising.
    assign pos_in[0] = str[rule_idx(SET_P, SET_N)];
    assign pos_in[1] = str[rule_idx(SET_P, SET_Z)];
    assign pos_in[2] = str[rule_idx(SET_P, SET_P)];
    assign pos_in[3] = str[rule_idx(SET_Z, SET_P)];

    fz_max_chain #(.GW(GW), .N(CHAIN)) u_neg (
        .din (neg_in),
        .y   (act_neg)
    );

    fz_max_chain #(.GW(GW), .N(CHAIN)) u_pos (
        .din (pos_in),
        .y   (act_pos)
    );

    // Zero drive has exactly one rule behind it.
    assign act_zer = str[rule_idx(SET_Z, SET_Z)];

    always_comb begin
        p_zero_single_r4: assert ((act_zer <= err_zer) && (act_zer <= chg_zer) &&
                                  ((act_zer == err_zer) || (act_zer == chg_zer)))
            else $error("zero drive not the zero/zero rule strength");
        p_neg_pick_r2: assert ((act_neg == neg_in[0]) || (act_neg == neg_in[1]) ||
                               (act_neg == neg_in[2]) || (act_neg == neg_in[3]))
            else $error("negative drive not one of its rule strengths");
        p_pos_pick_r3: assert ((act_pos == pos_in[0]) || (act_pos == pos_in[1]) ||
                               (act_pos == pos_in[2]) || (act_pos == pos_in[3]))
            else $error("positive drive not one of its rule strengths");
        p_neg_bound_r2: assert (act_neg <= ((err_neg > err_zer) ? err_neg : err_zer))
            else $error("negative drive exceeds its error premises");
        p_pos_bound_r3: assert (act_pos <= ((err_pos > err_zer) ? err_pos : err_zer))
            else $error("positive drive exceeds its error premises");
    end
endmodule

// File: tb/sim_mamdani_servo_infer.sv
module sim_mamdani_servo_infer;
    localparam int GW = 8;
    localparam int FS = (1 << GW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [GW-1:0] err_neg, err_zer, err_pos, chg_neg, chg_zer, chg_pos;
    logic [GW-1:0] act_neg, act_zer, act_pos;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    mamdani_servo_infer #(.GW(GW)) u0 (
        .err_neg (err_neg), .err_zer (err_zer), .err_pos (err_pos),
        .chg_neg (chg_neg), .chg_zer (chg_zer), .chg_pos (chg_pos),
        .act_neg (act_neg), .act_zer (act_zer), .act_pos (act_pos)
    );

    // Reference rule table: consequent per (error*3 + change); 0=N,1=Z,2=P.
    int cons_tab [9] = '{0, 0, 0, 0, 1, 2, 2, 2, 2};

    function automatic int ref_out(input int k, input int e[3], input int c[3]);
        int best = 0;
        for (int ei = 0; ei < 3; ei++) begin
            for (int ci = 0; ci < 3; ci++) begin
                int s = (e[ei] < c[ci]) ? e[ei] : c[ci];
                if (cons_tab[ei*3 + ci] == k && s > best) best = s;
            end
        end
        return best;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive on the falling edge, compare 1 ns later in the same cycle.
    task automatic apply(input string rq, input int en, input int ez, input int ep,
                         input int cn, input int cz, input int cp);
        int e[3];
        int c[3];
        e = '{en, ez, ep};
        c = '{cn, cz, cp};
        @(negedge clk);
        err_neg = GW'(en); err_zer = GW'(ez); err_pos = GW'(ep);
        chg_neg = GW'(cn); chg_zer = GW'(cz); chg_pos = GW'(cp);
        #1;
        chk((rq == "") ? "R2" : rq, "act_neg", int'(act_neg), ref_out(0, e, c));
        chk((rq == "") ? "R4" : rq, "act_zer", int'(act_zer), ref_out(1, e, c));
        chk((rq == "") ? "R3" : rq, "act_pos", int'(act_pos), ref_out(2, e, c));
    endtask

    initial begin
        err_neg = '0; err_zer = '0; err_pos = '0;
        chg_neg = '0; chg_zer = '0; chg_pos = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R6: idle state with all grades at zero
        apply("R6", 0, 0, 0, 0, 0, 0);
        // R7: full scale everywhere
        apply("R7", FS, FS, FS, FS, FS, FS);
        // R8: jump straight from full scale to a sparse vector, no settling cycle
        apply("R8", 0, 40, 0, 0, 0, 0);
        // R1: single active pair, output follows the smaller premise
        apply("R1", 200, 0, 0, 0, 90, 0);
        apply("R1", 0, 0, 60, 0, 0, 250);
        apply("R1", 0, 130, 0, 0, 210, 0);
        // R2: zero error with falling change drives the negative set
        apply("R2", 0, 180, 0, 120, 0, 0);
        apply("R2", 30, 220, 0, 150, 0, 0);
        // R3: zero error with rising change drives the positive set
        apply("R3", 0, 180, 0, 0, 0, 120);
        apply("R3", 0, 220, 25, 0, 0, 140);
        // R4: zero/zero rule alone, others present
        apply("R4", 90, 100, 80, 70, 100, 60);
        // R5: equal premises and equal competing strengths
        apply("R5", 0, 77, 0, 0, 77, 0);
        apply("R5", 66, 0, 66, 66, 66, 66);
        // R8: repeat a vector after a different one, same answer
        apply("R8", 200, 0, 0, 0, 90, 0);

        // Pseudo-random sweep, every output checked against the model.
        for (int i = 0; i < 400; i++) begin
            apply("", int'($urandom_range(0, FS)), int'($urandom_range(0, FS)),
                      int'($urandom_range(0, FS)), int'($urandom_range(0, FS)),
                      int'($urandom_range(0, FS)), int'($urandom_range(0, FS)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule